// File: doc/BRIEF.md
# NAND Ready/Busy Wait Controller

This block waits for a NAND flash device to finish an operation after a bus sequencer has issued the command. A one-cycle `start` pulse arms it. A small operation code selects one of three cases: a plain wait for a read, a device reset, or a program/erase completion. The `pin_mode` input says whether the device's ready/busy line is wired up. Every wait begins with a fixed guard interval that covers the time the device needs before it reports busy. After the guard the block either watches the synchronized ready/busy line or asks the sequencer for status bytes, and it checks the READY flag in each byte it receives.

When no pin is available, a plain wait becomes a fixed chip delay. A reset wait becomes a chip delay, one STATUS command and then status polling under its own shorter budget. Program and erase completion always sends a STATUS command, waits by pin or by polling, and then makes one final status read. The block reports completion with a `done` pulse. It raises `timeout` in the same cycle when the budget ran out and the device still looked busy. The last status byte it read stays on `status`.

All intervals are given in time units and converted to clock cycles from a clock-frequency parameter.

Top module: `nand_rb_waiter`

## Requirements
- R1: While reset is asserted and after it is released, `done`, `timeout` and `seq_req` are 0 and `status` is 8'h00.
- R2: No wait ends sooner than the guard interval after the accepted start. The guard length in cycles is ceil(TWB_NS*CLK_MHZ/1000). Readiness is not sampled during the guard, even if the device is already ready.
- R3: In pin mode with op 2'b00 (wait) or 2'b01 (reset), the ready/busy input passes through two flip-flops, and a low level means busy. The wait ends with `done` and no `timeout` once the synchronized level is high. No bus request is made.
- R4: In pin mode, if the line stays low for NORM_TMO_US after the guard, `done` and `timeout` pulse together.
- R5: With `pin_mode`=0 and an op other than 2'b01 or 2'b10, the block waits CHIP_DLY_US after the guard and then pulses `done` without `timeout`. It makes no bus request.
- R6: With `pin_mode`=0 and op 2'b01 (reset), the block waits the chip delay after the guard. It then issues one STATUS command (`seq_cmd`=1) and polls with reads (`seq_cmd`=0) until a byte has bit 6 (mask 8'h40) set. `status` ends holding that byte.
- R7: The reset polling of R6 has its own budget of RESET_TMO_US. If the budget expires and the last byte has bit 6 clear, `done` and `timeout` pulse together and `status` holds that byte.
- R8: With op 2'b10 (program/erase), the block first issues one STATUS command. It then waits by pin or by polling under the normal budget, and after that makes exactly one more status read. `status` holds that final byte, and `timeout` pulses with `done` exactly when its bit 6 is clear.
- R9: `done` and `timeout` are single-cycle pulses, and `timeout` is never high without `done`.
- R10: A `start` that arrives while a wait is in progress is ignored. It produces no extra `done` and no bus request.
- R11: `seq_req` stays high with `seq_cmd` unchanged until `seq_ack`. A read byte is taken from `seq_data` in the cycle `seq_ack` is high.
- R12: `status` changes only one cycle after an acknowledged read. Paths with no read leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request to begin a wait |
| op | input | 2 | 00 wait, 01 reset, 10 program/erase, 11 treated as wait |
| pin_mode | input | 1 | 1 when the ready/busy line is usable |
| rb_n_in | input | 1 | Ready/busy line from the device, low means busy (asynchronous) |
| seq_req | output | 1 | Request to the bus sequencer |
| seq_cmd | output | 1 | 1 send STATUS command, 0 read one status byte |
| seq_ack | input | 1 | Sequencer completed the request this cycle |
| seq_data | input | 8 | Status byte, valid with `seq_ack` on a read |
| done | output | 1 | Wait finished (one-cycle pulse) |
| timeout | output | 1 | Budget expired with device still busy (pulses with `done`) |
| status | output | 8 | Last status byte read |

## Verification
The hardest states to reach are the budget expiries. They happen only after thousands of cycles of a device that never becomes ready, and in polling mode the expiry can land while a read is still outstanding. The bench shrinks the time parameters so the budgets stay in the low thousands of cycles. A sequencer model answers every request after a fixed delay, and the bench scripts how many busy bytes it returns before a ready one, or makes it return busy bytes forever. The ready/busy line is held low forever, raised at a scripted cycle, or held high before start, so that the guard interval can be seen to dominate.

// File: rtl/nrw_pkg.sv
package nrw_pkg;

    typedef enum logic [1:0] {
        OP_WAIT      = 2'b00,
        OP_RESET     = 2'b01,
        OP_PROGERASE = 2'b10,
        OP_SPARE     = 2'b11
    } op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_GUARD,
        ST_CHIPDLY,
        ST_SEND_CMD,
        ST_PIN_WAIT,
        ST_POLL_RD,
        ST_FINAL_RD
    } state_e;

    function automatic int nrw_max(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/nrw_sync.sv
module nrw_sync #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_in,
    output logic q_out
);
    logic [STAGES-1:0] chain_q;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[0] <= RESET_VAL;
                    else        chain_q[0] <= d_in;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[g] <= RESET_VAL;
                    else        chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    assign q_out = chain_q[STAGES-1];
endmodule

// File: rtl/nrw_timer.sv
module nrw_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] val,
    output logic         expired
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)               cnt_d = val;
        else if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/nand_rb_waiter.sv
module nand_rb_waiter
    import nrw_pkg::*;
#(
    parameter int CLK_MHZ      = 100,
    parameter int TWB_NS       = 100,
    parameter int CHIP_DLY_US  = 20,
    parameter int NORM_TMO_US  = 400000,
    parameter int RESET_TMO_US = 250000,
    parameter int READY_BIT    = 6,
    parameter int SYNC_STAGES  = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [1:0] op,
    input  logic       pin_mode,
    input  logic       rb_n_in,
    output logic       seq_req,
    output logic       seq_cmd,
    input  logic       seq_ack,
    input  logic [7:0] seq_data,
    output logic       done,
    output logic       timeout,
    output logic [7:0] status
);
    localparam int TWB_CYC  = nrw_max(1, (TWB_NS * CLK_MHZ + 999) / 1000);
    localparam int CHIP_CYC = nrw_max(1, CHIP_DLY_US * CLK_MHZ);
    localparam int NORM_CYC = nrw_max(1, NORM_TMO_US * CLK_MHZ);
    localparam int RST_CYC  = nrw_max(1, RESET_TMO_US * CLK_MHZ);
    localparam int MAX_CYC  = nrw_max(nrw_max(TWB_CYC, CHIP_CYC), nrw_max(NORM_CYC, RST_CYC));
    localparam int CNT_W    = $clog2(MAX_CYC + 1);

    typedef struct packed {
        state_e     st;
        op_e        op;
        logic       pin;
        logic       done;
        logic       tmo;
        logic [7:0] status;
    } regs_t;

    regs_t r_d, r_q;

    logic             rb_ok;
    logic             t_load;
    logic [CNT_W-1:0] t_val;
    logic             t_exp;
    logic             is_prog;

    nrw_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (rb_n_in),
        .q_out (rb_ok)
    );

    nrw_timer #(.W(CNT_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (t_load),
        .val     (t_val),
        .expired (t_exp)
    );

    assign is_prog = (r_q.op == OP_PROGERASE);

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        r_d.tmo  = 1'b0;
        t_load   = 1'b0;
        t_val    = '0;
        seq_req  = 1'b0;
        seq_cmd  = 1'b0;

        unique case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    r_d.st  = ST_GUARD;
                    r_d.op  = op_e'(op);
                    r_d.pin = pin_mode;
                    t_load  = 1'b1;
                    t_val   = CNT_W'(TWB_CYC);
                end
            end
            ST_GUARD: begin
                if (t_exp) begin
                    if (is_prog) begin
                        r_d.st = ST_SEND_CMD;
                    end else if (r_q.pin) begin
                        r_d.st = ST_PIN_WAIT;
                        t_load = 1'b1;
                        t_val  = CNT_W'(NORM_CYC);
                    end else begin
                        r_d.st = ST_CHIPDLY;
                        t_load = 1'b1;
                        t_val  = CNT_W'(CHIP_CYC);
                    end
                end
            end
            ST_CHIPDLY: begin
                if (t_exp) begin
                    if (r_q.op == OP_RESET) begin
                        r_d.st = ST_SEND_CMD;
                    end else begin
                        r_d.st   = ST_IDLE;
                        r_d.done = 1'b1;
                    end
                end
            end
            ST_SEND_CMD: begin
                seq_req = 1'b1;
                seq_cmd = 1'b1;
                if (seq_ack) begin
                    t_load = 1'b1;
                    t_val  = (r_q.op == OP_RESET) ? CNT_W'(RST_CYC) : CNT_W'(NORM_CYC);
                    r_d.st = (is_prog && r_q.pin) ? ST_PIN_WAIT : ST_POLL_RD;
                end
            end
            ST_PIN_WAIT: begin
                if (rb_ok || t_exp) begin
                    if (is_prog) begin
                        r_d.st = ST_FINAL_RD;
                    end else begin
                        r_d.st   = ST_IDLE;
                        r_d.done = 1'b1;
                        r_d.tmo  = !rb_ok;
                    end
                end
            end
            ST_POLL_RD: begin
                seq_req = 1'b1;
                if (seq_ack) begin
                    r_d.status = seq_data;
                    if (seq_data[READY_BIT] || t_exp) begin
                        if (is_prog) begin
                            r_d.st = ST_FINAL_RD;
                        end else begin
                            r_d.st   = ST_IDLE;
                            r_d.done = 1'b1;
                            r_d.tmo  = !seq_data[READY_BIT];
                        end
                    end
                end
            end
            ST_FINAL_RD: begin
                seq_req = 1'b1;
                if (seq_ack) begin
                    r_d.status = seq_data;
                    r_d.st     = ST_IDLE;
                    r_d.done   = 1'b1;
                    r_d.tmo    = !seq_data[READY_BIT];
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st     <= ST_IDLE;
            r_q.op     <= OP_WAIT;
            r_q.pin    <= 1'b0;
            r_q.done   <= 1'b0;
            r_q.tmo    <= 1'b0;
            r_q.status <= 8'h00;
        end else begin
            r_q <= r_d;
        end
    end

    assign done    = r_q.done;
    assign timeout = r_q.tmo;
    assign status  = r_q.status;
endmodule

// File: rtl/nrw_checker.sv
module nrw_checker #(
    parameter int GUARD_CYC = 10
) (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic       seq_req,
    input logic       seq_cmd,
    input logic       seq_ack,
    input logic       done,
    input logic       timeout,
    input logic [7:0] status
);
    localparam int CW = $clog2(GUARD_CYC + 2) + 1;

    logic          busy_q;
    logic [CW-1:0] since_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            since_q <= '0;
        end else if (start && (!busy_q || done)) begin
            busy_q  <= 1'b1;
            since_q <= '0;
        end else begin
            if (done) busy_q <= 1'b0;
            if (since_q != {CW{1'b1}}) since_q <= since_q + 1'b1;
        end
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);                                              // R9
    AST_TMO_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |-> done);                                            // R9
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_req && !seq_ack) |=> (seq_req && $stable(seq_cmd)));     // R11
    AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(seq_req && seq_ack && !seq_cmd) |=> $stable(status));       // R12
    AST_GUARD_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (int'(since_q) >= GUARD_CYC));                       // R2
    AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_q |-> !seq_req);                                        // R10
endmodule

bind nand_rb_waiter nrw_checker #(.GUARD_CYC(TWB_CYC)) u_nrw_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .seq_req (seq_req),
    .seq_cmd (seq_cmd),
    .seq_ack (seq_ack),
    .done    (done),
    .timeout (timeout),
    .status  (status)
);

// File: tb/nand_rb_waiter_test.sv
module nand_rb_waiter_test;
    localparam int CLK_PERIOD = 10;
    localparam int MHZ   = 50;
    localparam int TWB   = 5;     // ceil(100*50/1000)
    localparam int CHIP  = 100;   // 2 us
    localparam int NORM  = 2000;  // 40 us
    localparam int RST   = 1250;  // 25 us
    localparam logic [7:0] RDY_BYTE  = 8'hE0;
    localparam logic [7:0] BUSY_BYTE = 8'hA0;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, pin_mode = 1'b0, rb_n_in = 1'b0;
    logic [1:0] op = 2'b00;
    logic seq_req, seq_cmd, seq_ack = 1'b0, done, timeout;
    logic [7:0] seq_data = 8'h00, status;

    int checks = 0, errors = 0;
    int rdy_after = -1, read_cnt = 0, cmd_cnt = 0, ack_dly = 0;
    int lat = 0, done_cycles = 0, tmo_seen = 0;
    logic [7:0] last_st = 8'h00;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    nand_rb_waiter #(
        .CLK_MHZ(MHZ), .TWB_NS(100), .CHIP_DLY_US(2),
        .NORM_TMO_US(40), .RESET_TMO_US(25)
    ) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .pin_mode(pin_mode),
        .rb_n_in(rb_n_in), .seq_req(seq_req), .seq_cmd(seq_cmd), .seq_ack(seq_ack),
        .seq_data(seq_data), .done(done), .timeout(timeout), .status(status)
    );

    // sequencer model: answers each request two cycles after it is seen
    initial begin
        forever begin
            @(negedge clk);
            if (seq_ack) begin
                seq_ack = 1'b0;
            end else if (seq_req) begin
                if (ack_dly == 2) begin
                    ack_dly = 0;
                    seq_ack = 1'b1;
                    if (seq_cmd) begin
                        seq_data = 8'h00;
                        cmd_cnt++;
                    end else begin
                        seq_data = (rdy_after >= 0 && read_cnt >= rdy_after) ? RDY_BYTE : BUSY_BYTE;
                        read_cnt++;
                    end
                end else begin
                    ack_dly++;
                end
            end else begin
                ack_dly = 0;
            end
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic check_rng(input string req, input int act, input int lo, input int hi);
        checks++;
        if (act < lo || act > hi) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi);
        end
    endtask

    // runs one wait; rb_rel: cycle after start when line goes high (-1 never, 0 before start)
    task automatic run(input logic [1:0] o, input logic pin, input int rb_rel, input int rdy);
        rdy_after = rdy; read_cnt = 0; cmd_cnt = 0;
        done_cycles = 0; tmo_seen = 0; lat = 0;
        last_st = status;
        @(negedge clk);
        rb_n_in = (rb_rel == 0);
        repeat (4) @(negedge clk);
        op = o; pin_mode = pin; start = 1'b1;
        for (int c = 1; c < 20000; c++) begin
            @(negedge clk);
            start = 1'b0;
            if (c == rb_rel) rb_n_in = 1'b1;
            if (done) begin
                if (done_cycles == 0) lat = c;
                done_cycles++;
                if (timeout) tmo_seen++;
            end else if (done_cycles > 0) begin
                break;
            end
        end
        rb_n_in = 1'b0;
    endtask

    typedef struct packed {
        logic [1:0] op;
        logic       pin;
        int         rb_rel;
        int         rdy;
        int         tmo;
        int         cmds;
        int         reads;   // -1: not checked
        int         st_kind; // 0 unchanged, 1 ready byte, 2 busy byte
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{2'b00, 1'b1,  0, -1, 0, 0,  0, 0},  // R3 pin already ready
        '{2'b00, 1'b1, 50, -1, 0, 0,  0, 0},  // R3 pin released later
        '{2'b00, 1'b0, -1, -1, 0, 0,  0, 0},  // R5 chip delay
        '{2'b01, 1'b0, -1,  3, 0, 1,  4, 1},  // R6 reset poll
        '{2'b10, 1'b1, 80,  0, 0, 1,  1, 1},  // R8 prog via pin
        '{2'b10, 1'b0, -1,  5, 0, 1,  7, 1},  // R8 prog via poll
        '{2'b01, 1'b0, -1, -1, 1, 1, -1, 2},  // R7 reset budget
        '{2'b00, 1'b1, -1, -1, 1, 0,  0, 0},  // R4 pin budget
        '{2'b10, 1'b1, -1, -1, 1, 1,  1, 2},  // R8 pin budget, final busy
        '{2'b10, 1'b0, -1, -1, 1, 1, -1, 2},  // R8 poll budget, final busy
        '{2'b01, 1'b1, 30, -1, 0, 0,  0, 0},  // R3 reset with pin
        '{2'b11, 1'b0, -1, -1, 0, 0,  0, 0}   // R5 spare op acts as wait
    };

    initial begin
        // R1 reset state
        #(CLK_PERIOD*3);
        check("R1 done", done, 0);
        check("R1 timeout", timeout, 0);
        check("R1 seq_req", seq_req, 0);
        check("R1 status", status, 0);
        @(negedge clk); rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 status after release", status, 0);
        check("R1 done after release", done, 0);

        for (int i = 0; i < NV; i++) begin
            vec_t v;
            logic [7:0] exp_st;
            v = VECS[i];
            run(v.op, v.pin, v.rb_rel, v.rdy);
            exp_st = (v.st_kind == 1) ? RDY_BYTE : (v.st_kind == 2) ? BUSY_BYTE : last_st;
            check($sformatf("R9 done width vec%0d", i), done_cycles, 1);
            check($sformatf("R4/R7/R8 timeout vec%0d", i), tmo_seen, v.tmo);
            check($sformatf("R6/R8 status cmds vec%0d", i), cmd_cnt, v.cmds);
            if (v.reads >= 0) check($sformatf("R6/R8 reads vec%0d", i), read_cnt, v.reads);
            check($sformatf("R12 status vec%0d", i), status, exp_st);
            if (i == 0) check_rng("R2 guard dominates ready pin", lat, TWB + 1, TWB + 6);
            if (i == 1) check_rng("R3 two-flop latency", lat, 52, 58);
            if (i == 2) check_rng("R5 chip delay latency", lat, TWB + CHIP, TWB + CHIP + 6);
            if (i == 6) check_rng("R7 reset budget latency", lat, TWB + CHIP + RST, TWB + CHIP + RST + 20);
            if (i == 7) check_rng("R4 normal budget latency", lat, TWB + NORM, TWB + NORM + 6);
        end

        // R10: second start during a wait is ignored
        rdy_after = -1; read_cnt = 0; cmd_cnt = 0;
        @(negedge clk);
        op = 2'b00; pin_mode = 1'b0; start = 1'b1;
        @(negedge clk); start = 1'b0;
        repeat (20) @(negedge clk);
        op = 2'b10; pin_mode = 1'b0; start = 1'b1;
        @(negedge clk); start = 1'b0;
        done_cycles = 0;
        for (int c = 0; c < 400; c++) begin
            @(negedge clk);
            if (done) done_cycles++;
        end
        check("R10 one done only", done_cycles, 1);
        check("R10 no bus request", cmd_cnt + read_cnt, 0);

        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; errors++;
            $display("FAIL watchdog actual=expired expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule